// File: doc/BRIEF.md
# Store-and-Forward Packet Gate

The gate holds an incoming packet stream until each packet has fully arrived. Beats are written into an internal circular store as they are accepted. None of them is offered downstream until the beat carrying the end-of-packet flag has been stored. When that beat lands, the packet is either committed or rolled back. A packet is rolled back if the most significant bit of its user sideband was raised on any of its beats. A rolled-back packet leaves no trace at the output, and the space it used is reused at once.

The output side reads committed words from the store in order. Data, user bits and the end-of-packet flag all come from the stored word. Because a packet is released only once it is complete, it leaves as one uninterrupted burst whenever the receiver is ready. The gate is meant to sit on a receive path, so that a frame found to be bad late in its arrival can be discarded before anything downstream sees it.

A synchronous clear empties the gate, as does reset. Either one discards committed and partly written packets alike.

Top module: `pkt_gate`

## Requirements
- R1: `out_valid` is never high unless at least one beat of a fully accepted, error-free packet is still waiting to be transferred. No beat is offered before its packet's last beat has been accepted.
- R2: A packet with `in_user[USER_W-1]` = 1 on any accepted beat, including its last, is discarded whole. None of its beats ever appears at the output.
- R3: Error-free packets leave in arrival order. Each beat carries unchanged `out_data` and `out_user`, and `out_last` is 1 only on each packet's final beat.
- R4: `in_ready` is low exactly when the store holds 2^ADDR_W words, counting committed unread beats plus beats of the packet being written. No stored word is overwritten.
- R5: Once a beat with `out_last` = 0 is transferred, `out_valid` is high in the very next cycle, so a committed packet is never broken up.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_user` and `out_last` hold their values into the next cycle.
- R7: A cycle with `clr` high empties the gate. In the next cycle `out_valid` is 0 and `in_ready` is 1, and all pending and partial packets are lost.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1.
- R9: A packet longer than 2^ADDR_W beats stalls with `in_ready` low and nothing at the output until `clr` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous flush, active high |
| in_data | input | DATA_W | Incoming beat payload |
| in_user | input | USER_W | Incoming sideband; top bit marks the packet bad |
| in_last | input | 1 | Final beat of the incoming packet |
| in_valid | input | 1 | Incoming beat present |
| in_ready | output | 1 | Gate can take a beat |
| out_data | output | DATA_W | Outgoing beat payload |
| out_user | output | USER_W | Outgoing sideband as stored |
| out_last | output | 1 | Final beat of the outgoing packet |
| out_valid | output | 1 | Outgoing beat present |
| out_ready | input | 1 | Receiver takes the beat |

## Verification
The checks assume that a source keeps its packets framed. Every packet ends with a beat that has `in_last` set, and the source never drops `in_valid` to abandon a packet midway except around a clear. The bench's driver only ever sends whole packets of explicit length. Beats are sent without a final flag only in the deliberate oversize case, and that case always ends in a clear. The assertions also take `clr` as a whole-cycle event. The bench raises it for exactly one cycle, with the receiver held off, so no burst is in flight when it strikes.

// File: rtl/pkt_gate_pkg.sv
package pkt_gate_pkg;

    // Default geometry for the gate: payload width, sideband width and log2 of store depth.
    localparam int unsigned PG_DATA_W = 64;
    localparam int unsigned PG_USER_W = 4;
    localparam int unsigned PG_ADDR_W = 10;

endpackage

// File: rtl/pkt_gate_wr.sv
// Write-side control: speculative and committed pointers, error latch, fill limit.
module pkt_gate_wr #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic              in_err,
    input  logic [ADDR_W:0]   rd_ptr,
    output logic              in_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W:0]   commit_ptr
);
    localparam int unsigned PTR_W = ADDR_W + 1;
    localparam logic [PTR_W-1:0] FULL_LVL = {1'b1, {ADDR_W{1'b0}}};

    typedef struct packed {
        logic [PTR_W-1:0] spec;
        logic [PTR_W-1:0] commit;
        logic             bad;
    } wr_state_t;

    wr_state_t s_d, s_q;
    logic [PTR_W-1:0] used;
    logic             room;
    logic             take;

    always_comb begin
        used = s_q.spec - rd_ptr;
        room = (used != FULL_LVL);
        take = in_valid && room && !clr;
        s_d  = s_q;
        if (clr) begin
            s_d = '0;
        end else if (take) begin
            if (in_last) begin
                if (s_q.bad || in_err) begin
                    s_d.spec = s_q.commit;
                end else begin
                    s_d.spec   = s_q.spec + PTR_W'(1);
                    s_d.commit = s_q.spec + PTR_W'(1);
                end
                s_d.bad = 1'b0;
            end else begin
                s_d.spec = s_q.spec + PTR_W'(1);
                s_d.bad  = s_q.bad || in_err;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready   = room;
    assign wr_en      = take;
    assign wr_addr    = s_q.spec[ADDR_W-1:0];
    assign commit_ptr = s_q.commit;

endmodule

// File: rtl/pkt_gate_mem.sv
// Simple dual-port store: one synchronous write port, one registered read port.
module pkt_gate_mem #(
    parameter int unsigned WORD_W = 69,
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] store [DEPTH];
    logic [WORD_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_word;
        end
        rd_q <= store[rd_addr];
    end

    assign rd_word = rd_q;

endmodule

// File: rtl/pkt_gate_rd.sv
// Read-side control: read pointer and output valid, fed only from committed words.
module pkt_gate_rd #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [ADDR_W:0]   commit_ptr,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [ADDR_W:0]   rd_ptr,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam int unsigned PTR_W = ADDR_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             vld;
    } rd_state_t;

    rd_state_t s_d, s_q;
    logic      moved;

    always_comb begin
        moved = s_q.vld && out_ready;
        s_d   = s_q;
        if (clr) begin
            s_d = '0;
        end else begin
            s_d.ptr = s_q.ptr + PTR_W'(moved);
            s_d.vld = (s_d.ptr != commit_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.vld;
    assign rd_ptr    = s_q.ptr;
    assign rd_addr   = s_d.ptr[ADDR_W-1:0];

endmodule

// File: rtl/pkt_gate.sv
// Store-and-forward packet gate: a packet is released only after its last beat is stored error-free.
module pkt_gate #(
    parameter int unsigned DATA_W = pkt_gate_pkg::PG_DATA_W,
    parameter int unsigned USER_W = pkt_gate_pkg::PG_USER_W,
    parameter int unsigned ADDR_W = pkt_gate_pkg::PG_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [USER_W-1:0] in_user,
    input  logic              in_last,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [USER_W-1:0] out_user,
    output logic              out_last,
    output logic              out_valid,
    input  logic              out_ready
);
    localparam int unsigned WORD_W = 1 + USER_W + DATA_W;

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W:0]   commit_ptr;
    logic [ADDR_W:0]   rd_ptr;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] rd_word;

    assign wr_word = {in_last, in_user, in_data};

    pkt_gate_wr #(.ADDR_W(ADDR_W)) i_wr (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .in_err     (in_user[USER_W-1]),
        .rd_ptr     (rd_ptr),
        .in_ready   (in_ready),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .commit_ptr (commit_ptr)
    );

    pkt_gate_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_word (wr_word),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    pkt_gate_rd #(.ADDR_W(ADDR_W)) i_rd (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .commit_ptr (commit_ptr),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .rd_ptr     (rd_ptr),
        .rd_addr    (rd_addr)
    );

    assign {out_last, out_user, out_data} = rd_word;

endmodule

// File: rtl/pkt_gate_chk.sv
// Port-level checker: keeps its own count of committed and partial beats.
module pkt_gate_chk #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned USER_W = 4,
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              clr,
    input logic [USER_W-1:0] in_user,
    input logic              in_last,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [USER_W-1:0] out_user,
    input logic              out_last,
    input logic              out_valid,
    input logic              out_ready
);
    localparam int unsigned CW    = ADDR_W + 2;
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [CW-1:0] part_q;
    logic [CW-1:0] comm_q;
    logic          bad_q;
    logic          in_x;
    logic          out_x;

    assign in_x  = in_valid && in_ready;
    assign out_x = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            part_q <= '0;
            comm_q <= '0;
            bad_q  <= 1'b0;
        end else begin
            if (in_x && in_last) begin
                part_q <= '0;
                bad_q  <= 1'b0;
                if (bad_q || in_user[USER_W-1]) begin
                    comm_q <= comm_q - CW'(out_x);
                end else begin
                    comm_q <= comm_q + part_q + CW'(1) - CW'(out_x);
                end
            end else begin
                part_q <= part_q + CW'(in_x);
                bad_q  <= bad_q || (in_x && in_user[USER_W-1]);
                comm_q <= comm_q - CW'(out_x);
            end
        end
    end

    // R1: nothing is offered unless a committed beat is outstanding
    p_release_r1: assert property (@(posedge clk) disable iff (rst || clr)
        out_valid |-> (comm_q != '0));

    // R4: the fill limit matches the count of stored beats
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst || clr)
        in_ready == ((part_q + comm_q) < CW'(DEPTH)));

    // R5: a packet leaves without gaps
    p_burst_r5: assert property (@(posedge clk) disable iff (rst || clr)
        (out_valid && out_ready && !out_last) |=> out_valid);

    // R6: a stalled beat stays put
    p_hold_r6: assert property (@(posedge clk) disable iff (rst || clr)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_user) && $stable(out_last)));

    // R7: a flush leaves the gate empty and open
    p_flush_r7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!out_valid && in_ready));

endmodule

bind pkt_gate pkt_gate_chk #(.DATA_W(DATA_W), .USER_W(USER_W), .ADDR_W(ADDR_W)) i_pkt_gate_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .in_user   (in_user),
    .in_last   (in_last),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_user  (out_user),
    .out_last  (out_last),
    .out_valid (out_valid),
    .out_ready (out_ready)
);

// File: tb/test_pkt_gate.sv
`timescale 1ns/1ps
module test_pkt_gate;
    localparam int AW = 4;
    localparam int DW = 64;
    localparam int UW = 4;
    localparam int DEPTH = 1 << AW;
    localparam int WW = DW + UW + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [UW-1:0] in_user = '0;
    logic          in_last = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] out_data;
    logic [UW-1:0] out_user;
    logic          out_last;
    logic          out_valid;
    logic          out_ready = 1'b0;

    always #2 clk = ~clk;

    pkt_gate #(.DATA_W(DW), .USER_W(UW), .ADDR_W(AW)) i_pkt_gate (
        .clk(clk), .rst(rst), .clr(clr),
        .in_data(in_data), .in_user(in_user), .in_last(in_last),
        .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_user(out_user), .out_last(out_last),
        .out_valid(out_valid), .out_ready(out_ready)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [WW-1:0] exp_q [0:4095];
    int exp_wr = 0;
    int exp_rd = 0;
    logic [WW-1:0] pend [0:63];
    int bp_mode = 0;
    logic [15:0] lf_o = 16'hACE1;
    logic [15:0] lf_i = 16'h1D2B;
    bit prev_nl = 0;

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Receiver: decides ready away from the edge, then checks the beat it takes.
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                out_ready = 1'b0;
                prev_nl = 0;
            end else begin
                lf_o = {lf_o[14:0], lf_o[15] ^ lf_o[13] ^ lf_o[12] ^ lf_o[10]};
                case (bp_mode)
                    0: out_ready = 1'b1;
                    1: out_ready = lf_o[0] | lf_o[3];
                    default: out_ready = 1'b0;
                endcase
                if (out_valid) begin
                    // R1: only committed beats may be offered
                    check(exp_rd < exp_wr, "R1 valid without committed beat", 128'(out_valid), 128'(0));
                end
                if (prev_nl && bp_mode == 0) begin
                    // R5: burst continues after a non-final beat
                    check(out_valid, "R5 burst gap", 128'(out_valid), 128'(1));
                end
                prev_nl = 0;
                if (out_valid && out_ready) begin
                    if (exp_rd < exp_wr) begin
                        // R2, R3: only good packets, in order, unchanged
                        check({out_last, out_user, out_data} == exp_q[exp_rd & 4095], "R3 beat mismatch (R2 order)",
                              128'({out_last, out_user, out_data}), 128'(exp_q[exp_rd & 4095]));
                        exp_rd++;
                    end
                    prev_nl = !out_last;
                end
            end
        end
    end

    task automatic send_pkt(input int id, input int len, input int errpos, input bit gaps, input bit end_flag);
        bit bad_pkt = 0;
        for (int b = 0; b < len; b++) begin
            bit done = 0;
            while (!done) begin
                @(negedge clk);
                lf_i = {lf_i[14:0], lf_i[15] ^ lf_i[13] ^ lf_i[12] ^ lf_i[10]};
                if (gaps && lf_i[1:0] == 2'b00) begin
                    in_valid = 1'b0;
                    @(posedge clk);
                end else begin
                    bit acc;
                    in_valid = 1'b1;
                    in_data  = {16'hA5C3, 16'(id), 32'(b)};
                    in_user  = {(b == errpos), 3'(b)};
                    in_last  = end_flag && (b == len - 1);
                    acc = in_ready;
                    @(posedge clk);
                    if (acc) begin
                        done = 1;
                        pend[b] = {in_last, in_user, in_data};
                        if (b == errpos) bad_pkt = 1;
                    end
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
        if (end_flag && !bad_pkt) begin
            for (int b = 0; b < len; b++) begin
                exp_q[exp_wr & 4095] = pend[b];
                exp_wr++;
            end
        end
    endtask

    task automatic drain(input string req);
        int t = 0;
        while (exp_rd != exp_wr && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        check(exp_rd == exp_wr, req, 128'(exp_rd), 128'(exp_wr));
        check(!out_valid, {req, " extra output"}, 128'(out_valid), 128'(0));
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        exp_rd = exp_wr;
    endtask

    initial begin
        int id = 1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        check(!out_valid, "R8 out_valid after reset", 128'(out_valid), 128'(0));
        check(in_ready, "R8 in_ready after reset", 128'(in_ready), 128'(1));

        // R2 R3: sweep of lengths and error positions (-1 = clean) under varying back-pressure
        for (int len = 1; len <= 10; len++) begin
            for (int ep = -1; ep < len; ep++) begin
                bp_mode = ((len + ep) % 3 == 0) ? 0 : 1;
                send_pkt(id, len, ep, (ep % 2) != 0, 1'b1);
                id++;
            end
        end
        drain("R3 sweep drain");

        // R1: a packet held back by the receiver still waits for its last beat
        bp_mode = 2;
        send_pkt(id, 2, -1, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check(!out_valid, "R1 partial packet visible", 128'(out_valid), 128'(0));
        pulse_clear();
        id++;

        // R4: two committed 8-beat packets fill the store, input stalls
        send_pkt(id, DEPTH / 2, -1, 1'b0, 1'b1);
        id++;
        send_pkt(id, DEPTH / 2, -1, 1'b0, 1'b1);
        id++;
        repeat (2) @(negedge clk);
        check(!in_ready, "R4 full store still ready", 128'(in_ready), 128'(0));
        check(out_valid, "R4 full store not offering", 128'(out_valid), 128'(1));
        bp_mode = 1;
        drain("R4 drain after full");
        check(in_ready, "R4 ready after drain", 128'(in_ready), 128'(1));

        // R9: oversize packet stalls; R7: clear recovers
        bp_mode = 2;
        send_pkt(id, DEPTH, -1, 1'b0, 1'b0);
        id++;
        repeat (4) @(negedge clk);
        check(!in_ready, "R9 oversize not stalled", 128'(in_ready), 128'(0));
        check(!out_valid, "R9 oversize leaked", 128'(out_valid), 128'(0));
        pulse_clear();
        check(in_ready, "R7 in_ready after clear", 128'(in_ready), 128'(1));
        check(!out_valid, "R7 out_valid after clear", 128'(out_valid), 128'(0));
        bp_mode = 0;
        send_pkt(id, 3, -1, 1'b0, 1'b1);
        id++;
        drain("R7 packet after oversize clear");

        // R7: committed but unsent packet is lost on clear
        bp_mode = 2;
        send_pkt(id, 3, -1, 1'b0, 1'b1);
        id++;
        repeat (3) @(negedge clk);
        check(out_valid, "R6 committed packet held", 128'(out_valid), 128'(1));
        pulse_clear();
        check(!out_valid, "R7 committed packet survived clear", 128'(out_valid), 128'(0));
        bp_mode = 1;
        send_pkt(id, 5, -1, 1'b1, 1'b1);
        id++;
        send_pkt(id, 4, 3, 1'b0, 1'b1);
        id++;
        send_pkt(id, 1, -1, 1'b0, 1'b1);
        id++;
        drain("R2 tail after clear");

        wrap_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired act=running exp=done");
        wrap_up();
    end

endmodule